// File: doc/BRIEF.md
# Output Buffer Status and Interrupt Arbiter

This block sits between the two receive channels of a keyboard/pointer host controller and the host-facing registers. Each channel, keyboard and auxiliary, raises a level while it holds a byte waiting for the host. The block merges those two levels with the controller's mode byte and the self-test flag. From them it produces four results:

- the eight-bit status byte the host polls;
- the keyboard interrupt request;
- the auxiliary interrupt request;
- a select that tells the data-port read path which channel's byte to return.

The keyboard channel wins whenever both channels are pending. The auxiliary channel is therefore visible to the host only when it is the sole source of data. The keyboard interrupt can also be silenced by the keyboard-disable mode bit. All outputs are registered. Each one reflects the inputs sampled at the previous rising clock edge.

Top module: `obuf_irq_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, status_byte reads 0x18, kbd_irq and aux_irq are 0, and rd_sel_aux is 0.
- R2: Status bit 0 (data waiting) is 1 exactly when kbd_pending or aux_pending was 1 at the previous rising edge.
- R3: Status bit 5 (auxiliary data waiting) is 1 exactly when, at the previous edge, aux_pending was 1 and kbd_pending was 0.
- R4: kbd_irq is 1 exactly when, at the previous edge, kbd_pending was 1, mode_reg bit 0 (keyboard interrupt enable) was 1 and mode_reg bit 4 (keyboard disable) was 0.
- R5: aux_irq is 1 exactly when, at the previous edge, aux_pending was 1, kbd_pending was 0 and mode_reg bit 1 (auxiliary interrupt enable) was 1.
- R6: rd_sel_aux (1 = read auxiliary byte, 0 = read keyboard byte) is 1 exactly when, at the previous edge, aux_pending was 1 and kbd_pending was 0.
- R7: Status bit 2 follows selftest_flag with one cycle of delay. Bits 3 (command flag) and 4 (unlocked) are always 1. Bits 1 (input full), 6 (timeout) and 7 (parity error) are always 0.
- R8: When both channels are pending, aux_irq is 0 and status bit 5 is 0, whatever the mode bits are.
- R9: mode_reg bits 2, 3, 5, 6 and 7 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kbd_pending | input | 1 | Keyboard channel holds a byte |
| aux_pending | input | 1 | Auxiliary channel holds a byte |
| mode_reg | input | 8 | Controller mode byte |
| selftest_flag | input | 1 | Self-test completed flag |
| status_byte | output | 8 | Host-visible status byte |
| kbd_irq | output | 1 | Keyboard interrupt request |
| aux_irq | output | 1 | Auxiliary interrupt request |
| rd_sel_aux | output | 1 | Data-read source, 1 selects auxiliary |

## Verification
The assertions assume the inputs are stable levels around each rising edge. They compare every output against the inputs captured one edge earlier, and they only start doing so once a full cycle has passed outside reset. The stimulus changes all inputs on the falling edge, drawing each pending level and the whole mode byte at random so that every pending combination meets every mode pattern. Directed steps add the both-pending case with every interrupt enable set and with the disable bit toggled.

// File: rtl/obuf_irq_arbiter.sv
module obuf_irq_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kbd_pending,
  input  logic       aux_pending,
  input  logic [7:0] mode_reg,
  input  logic       selftest_flag,
  output logic [7:0] status_byte,
  output logic       kbd_irq,
  output logic       aux_irq,
  output logic       rd_sel_aux
);

  logic any_pend, aux_only, kbd_req, aux_req;
  logic [7:0] status_nxt;

  assign any_pend = kbd_pending | aux_pending;
  assign aux_only = aux_pending & ~kbd_pending;
  assign kbd_req  = kbd_pending & mode_reg[0] & ~mode_reg[4];
  assign aux_req  = aux_only & mode_reg[1];

  assign status_nxt = {2'b00, aux_only, 2'b11, selftest_flag, 1'b0, any_pend};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_byte <= 8'h18;
      kbd_irq     <= 1'b0;
      aux_irq     <= 1'b0;
      rd_sel_aux  <= 1'b0;
    end else begin
      status_byte <= status_nxt;
      kbd_irq     <= kbd_req;
      aux_irq     <= aux_req;
      rd_sel_aux  <= aux_only;
    end
  end

endmodule

// File: rtl/obuf_irq_arbiter_chk.sv
module obuf_irq_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       kbd_pending,
  input logic       aux_pending,
  input logic [7:0] mode_reg,
  input logic       selftest_flag,
  input logic [7:0] status_byte,
  input logic       kbd_irq,
  input logic       aux_irq,
  input logic       rd_sel_aux
);

  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  a_r1_reset_state: assert property (@(posedge clk) !rst_n |=> (status_byte == 8'h18 && !kbd_irq && !aux_irq && !rd_sel_aux));

  a_r2_obf: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (status_byte[0] == ($past(kbd_pending) | $past(aux_pending))));

  a_r3_aux_obf: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (status_byte[5] == ($past(aux_pending) & ~$past(kbd_pending))));

  a_r4_kbd_irq: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (kbd_irq == ($past(kbd_pending) & $past(mode_reg[0]) & ~$past(mode_reg[4]))));

  a_r5_aux_irq: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (aux_irq == ($past(aux_pending) & ~$past(kbd_pending) & $past(mode_reg[1]))));

  a_r6_rd_sel: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (rd_sel_aux == ($past(aux_pending) & ~$past(kbd_pending))));

  a_r7_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (status_byte[4:3] == 2'b11 && status_byte[7:6] == 2'b00 && !status_byte[1]
                 && status_byte[2] == $past(selftest_flag)));

  a_r8_both_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(kbd_pending) && $past(aux_pending)) |-> (!aux_irq && !status_byte[5] && !rd_sel_aux));

endmodule

bind obuf_irq_arbiter obuf_irq_arbiter_chk u_chk (.*);

// File: tb/obuf_irq_arbiter_tb.sv
module obuf_irq_arbiter_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic kbd_pending = 0, aux_pending = 0, selftest_flag = 0;
  logic [7:0] mode_reg = 8'h03;
  logic [7:0] status_byte;
  logic kbd_irq, aux_irq, rd_sel_aux;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  obuf_irq_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .kbd_pending(kbd_pending), .aux_pending(aux_pending),
    .mode_reg(mode_reg), .selftest_flag(selftest_flag), .status_byte(status_byte),
    .kbd_irq(kbd_irq), .aux_irq(aux_irq), .rd_sel_aux(rd_sel_aux));

  function automatic logic [7:0] exp_status(logic k, logic a, logic st);
    return {2'b00, a & ~k, 2'b11, st, 1'b0, k | a};
  endfunction
  function automatic logic exp_kirq(logic k, logic [7:0] m);
    return k & m[0] & ~m[4];
  endfunction
  function automatic logic exp_airq(logic k, logic a, logic [7:0] m);
    return a & ~k & m[1];
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic apply_and_check(logic k, logic a, logic [7:0] m, logic st);
    kbd_pending = k; aux_pending = a; mode_reg = m; selftest_flag = st;
    @(negedge clk);
    chk("R2/R3/R7 status", status_byte, exp_status(k, a, st));
    chk("R4 kbd_irq", {7'd0, kbd_irq}, {7'd0, exp_kirq(k, m)});
    chk("R5/R8 aux_irq", {7'd0, aux_irq}, {7'd0, exp_airq(k, a, m)});
    chk("R6 rd_sel_aux", {7'd0, rd_sel_aux}, {7'd0, a & ~k});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'd20251);
    kbd_pending = 1; aux_pending = 1; selftest_flag = 1; mode_reg = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: reset state held despite active inputs
    chk("R1 reset status", status_byte, 8'h18);
    chk("R1 reset irqs", {5'd0, kbd_irq, aux_irq, rd_sel_aux}, 8'h00);
    rst_n = 1;
    chk("R1 first cycle", status_byte, 8'h18);
    @(negedge clk);
    // Directed corner cases
    apply_and_check(0, 0, 8'h03, 0);
    apply_and_check(1, 0, 8'h03, 0);   // R4 keyboard irq
    apply_and_check(1, 0, 8'h13, 0);   // R4 disable bit suppresses
    apply_and_check(0, 1, 8'h02, 0);   // R5 aux only
    apply_and_check(0, 1, 8'h01, 1);   // R5 enable clear, R7 selftest
    apply_and_check(1, 1, 8'hFF, 1);   // R8 both pending, all mode bits
    apply_and_check(1, 1, 8'h03, 0);   // R8
    apply_and_check(1, 1, 8'h13, 0);   // R8 with disable
    // R9: unused mode bits have no effect
    apply_and_check(1, 0, 8'hED, 0);
    apply_and_check(0, 1, 8'hEE, 1);
    apply_and_check(1, 0, 8'h01, 0);
    // Random stimulus
    for (int i = 0; i < 400; i++) begin
      r = $urandom;
      apply_and_check(r[0], r[1], r[15:8], r[2]);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule